// File: doc/BRIEF.md
# Sequential Add-and-Shift Multiplier

This block forms the unsigned product of two `WIDTH`-bit operands over several clock cycles, spending one cycle per multiplier bit. A pulse on `start` while the block is idle captures both operands: the multiplicand goes into a `WIDTH`-bit register, and the multiplier goes into the low half of a `2*WIDTH`-bit product register whose upper half is cleared. Each following cycle looks at the least significant bit of the product register. If that bit is set, a `WIDTH+1`-bit adder adds the multiplicand to the upper half. In the same cycle the whole register, including the adder's carry, shifts right by one place.

After `WIDTH` such steps the product register holds the full product, and `ready` goes high again. The product stays on `prod` until the next accepted start. The number of cycles does not depend on the operand values. A caller raises `start` while `ready` is high and reads `prod` once `ready` returns. A `start` held high runs operations back to back.

Top module: `seq_shift_mult`

## Requirements
- R1: While `rst` is high and after it is released, with no start, `ready` is 1 and `prod` is 0.
- R2: When `start` is 1 in a cycle where `ready` is 1, the operands are captured at that clock edge and `ready` is 0 from that edge onward.
- R3: When `ready` returns to 1, `prod` equals `op_a * op_b` as unsigned numbers, using the values captured at the start edge.
- R4: A `start` pulse while `ready` is 0 is ignored: neither the result nor the completion time of the running operation changes.
- R5: While `ready` is 1 and `start` is 0, `prod` holds its value, and changes on `op_a` and `op_b` have no effect on it.
- R6: Changes on `op_a` and `op_b` after the start edge do not affect the running operation.
- R7: `ready` stays 0 for exactly `WIDTH` clock cycles after the start edge, for every operand value, including a multiplier of 0 and of all ones.
- R8: The largest operands, (2^WIDTH-1) times (2^WIDTH-1), produce the exact `2*WIDTH`-bit product with no lost carry.
- R9: If `start` is still 1 in the cycle where `ready` has returned, a new operation begins at the next edge with the operand values present then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication; accepted only while `ready` is 1 |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| prod | output | 2*WIDTH | Product register contents; valid while `ready` is 1 |
| ready | output | 1 | 1 when idle and able to accept `start` |

## Verification
The start edge is the first clock edge at which `start` and `ready` are both 1. At the falling edge right after it, `ready` must already read 0. The result is due at the `WIDTH`-th rising edge after the start edge. The bench samples only at falling edges. It counts how many falling edges show `ready` low, expects exactly `WIDTH` of them, and reads `prod` at the first falling edge where `ready` is high again. Disturbances (a second start, changed operands) are placed at falling edges inside that window, so the edge where each one could act is known.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } mult_state_e;

endpackage

// File: rtl/mult_step_ctr.sv
module mult_step_ctr #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic final_step
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_regs_t;

    ctr_regs_t r_q;
    ctr_regs_t r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = CW'(WIDTH);
        end else if (step) begin
            r_d.cnt = r_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Decrement reaches zero in this cycle: decision made on the next value
    assign final_step = (r_q.cnt == CW'(1));

    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt <= CW'(WIDTH));

    assert_cnt_live_R7: assert property (@(posedge clk) disable iff (rst)
        step |-> (r_q.cnt != '0));

endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import seq_mult_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic final_step,
    output logic load,
    output logic step,
    output logic ready
);
    typedef struct packed {
        mult_state_e state;
    } ctrl_regs_t;

    ctrl_regs_t r_q;
    ctrl_regs_t r_d;

    always_comb begin
        r_d   = r_q;
        load  = 1'b0;
        step  = 1'b0;
        ready = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                ready = 1'b1;
                if (start) begin
                    load      = 1'b1;
                    r_d.state = ST_STEP;
                end
            end
            ST_STEP: begin
                step = 1'b1;
                if (final_step) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_IDLE && start) |=> !ready);

    assert_finish_R7: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_STEP && final_step) |=> ready);

    assert_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_STEP && !final_step) |=> !ready);

endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] mcand;
        logic [PW-1:0]    acc;
    } dp_regs_t;

    dp_regs_t r_q;
    dp_regs_t r_d;

    logic [WIDTH:0] partial;

    always_comb begin
        r_d     = r_q;
        partial = {1'b0, r_q.acc[PW-1:WIDTH]}
                + (r_q.acc[0] ? {1'b0, r_q.mcand} : '0);
        if (load) begin
            r_d.mcand = mcand_in;
            r_d.acc   = {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            // carry, upper sum and remaining multiplier bits move right together
            r_d.acc = {partial, r_q.acc[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prod = r_q.acc;

    assert_onehot_ctl_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load, step}));

    assert_mcand_keep_R6: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(r_q.mcand));

endmodule

// File: rtl/seq_shift_mult.sv
module seq_shift_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod,
    output logic               ready
);
    logic load;
    logic step;
    logic final_step;

    mult_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .final_step (final_step),
        .load       (load),
        .step       (step),
        .ready      (ready)
    );

    mult_step_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .final_step (final_step)
    );

    mult_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (op_a),
        .mplier_in (op_b),
        .prod      (prod)
    );

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> $stable(prod));

endmodule

// File: tb/seq_shift_mult_bench.sv
module seq_shift_mult_bench;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [PW-1:0] prod;
    logic          ready;

    int total = 0;
    int bad   = 0;

    always #10ns clk = ~clk;

    seq_shift_mult #(.WIDTH(W)) u_seq_shift_mult (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op_a  (op_a),
        .op_b  (op_b),
        .prod  (prod),
        .ready (ready)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One operation; disturb adds a busy start pulse and scrambled operands (R4, R6)
    task automatic run_op(input int a, input int b, input bit disturb);
        int lat;
        longint exp;
        exp = longint'(a) * longint'(b);
        @(negedge clk);
        op_a  = W'(a);
        op_b  = W'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R2", longint'(ready), 0);
        if (disturb) begin
            op_a  = ~W'(a);
            op_b  = ~W'(b);
            start = 1'b1;
        end
        lat = 1;
        while (lat < 100) begin
            @(negedge clk);
            start = 1'b0;
            if (ready) break;
            lat++;
        end
        check(lat == W, "R7", lat, W);
        check(prod == PW'(exp), disturb ? "R3/R4/R6" : "R3", longint'(prod), exp);
    endtask

    initial begin
        #(20ns * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint keep;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1", longint'(ready), 1);
        check(prod == '0, "R1", longint'(prod), 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ready == 1'b1, "R1", longint'(ready), 1);
        check(prod == '0, "R1", longint'(prod), 0);

        // R7 corner multipliers, R8 largest operands
        run_op(200, 0, 1'b0);
        run_op(200, 255, 1'b0);
        run_op(255, 255, 1'b0);
        check(prod == 16'hFE01, "R8", longint'(prod), 65025);
        run_op(0, 255, 1'b0);

        // R5: idle with changing operands, no start
        keep = longint'(prod);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            op_a = W'(i * 37 + 5);
            op_b = W'(i * 91 + 3);
        end
        @(negedge clk);
        check(prod == PW'(keep), "R5", longint'(prod), keep);
        check(ready == 1'b1, "R5", longint'(ready), 1);

        // R4 and R6: busy start and operand changes are ignored
        run_op(123, 45, 1'b1);
        run_op(255, 1, 1'b1);
        run_op(1, 128, 1'b1);

        // R9: start held high runs two operations back to back
        @(negedge clk);
        op_a  = 8'd77;
        op_b  = 8'd99;
        start = 1'b1;
        @(negedge clk);
        op_a = 8'd13;
        op_b = 8'd250;
        begin
            int lat;
            lat = 1;
            while (lat < 100) begin
                @(negedge clk);
                if (ready) break;
                lat++;
            end
            check(lat == W, "R9", lat, W);
            check(prod == PW'(77 * 99), "R9", longint'(prod), 77 * 99);
            @(negedge clk);
            start = 1'b0;
            check(ready == 1'b0, "R9", longint'(ready), 0);
            lat = 1;
            while (lat < 100) begin
                @(negedge clk);
                if (ready) break;
                lat++;
            end
            check(lat == W, "R9", lat, W);
            check(prod == PW'(13 * 250), "R9", longint'(prod), 13 * 250);
        end

        // R3: near-exhaustive sweeps
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 17) begin
                run_op(a, b, 1'b0);
            end
        end
        for (int b = 0; b < 256; b++) begin
            run_op(0, b, 1'b0);
            run_op(1, b, 1'b0);
            run_op(128, b, 1'b0);
            run_op(170, b, 1'b0);
            run_op(255, b, 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule